// File: doc/BRIEF.md
# Omega Multistage Switching Network

This block joins NPORT input ports to NPORT output ports (NPORT a power of two) through log2(NPORT) columns of two-by-two switches. A perfect-shuffle wiring feeds each column. Each input may present one message per cycle. A message is a valid flag, a destination port index and a payload. The network routes every offered message in the same cycle it is sampled. The results appear on registered outputs one clock later. Each output port shows a valid flag, the payload it received and the index of the input that sent it.

Each switch sets itself separately for every message. In column k it compares bit k of the source index and bit k of the destination index, counting from the most significant bit. Equal bits pass the message straight through. Unequal bits cross it over. Two messages can need the same internal link. In that case the message entering the switch on its lower-numbered line keeps the link and the other is discarded for that cycle. Every input that offered a message gets one flag back a cycle later: delivered or blocked. Blocked senders retry on their own, outside this block.

Top module: `omega_net`

## Requirements
- R1: A delivered message appears on the output whose index equals its destination index, carrying its own payload and its source index. With NPORT=8, a message from input 1 to destination 4 arrives on output 4.
- R2: A message offered alone, for any source and any destination, is always delivered.
- R3: When two messages need the same switch output, the one entering that switch on the lower-numbered line wins. With NPORT=8, input 2 to destination 7 and input 6 to destination 4 offered together: input 2 is delivered and input 6 is blocked.
- R4: For every input that offers a valid message, exactly one of its delivered and blocked flags is high in the following cycle.
- R5: Outputs and flags change one clock after the inputs are sampled, and not before.
- R6: An input without a valid message produces no valid output and raises neither its delivered nor its blocked flag.
- R7: While reset (rst_n low) is asserted, all output valids and all delivered and blocked flags are 0.
- R8: The number of valid outputs in a cycle equals the number of delivered flags in that cycle.
- R9: The identity pattern and every cyclic shift (input i to destination (i+s) mod NPORT, all inputs valid) pass with every message delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | NPORT | Per-input message valid |
| in_dest | input | NPORT x log2(NPORT) | Per-input destination port index |
| in_data | input | NPORT x DATA_W | Per-input payload |
| out_valid | output | NPORT | Per-output message present |
| out_data | output | NPORT x DATA_W | Per-output payload |
| out_src | output | NPORT x log2(NPORT) | Per-output index of the sending input |
| in_delivered | output | NPORT | Per-input flag: last cycle's message was delivered |
| in_blocked | output | NPORT | Per-input flag: last cycle's message was blocked |

## Verification
On every cycle the assertions check three things. Each valid output matches a message sampled one cycle earlier, with the right destination, payload and source. Valid inputs get exactly one flag back and idle inputs get none. The counts of outputs and deliveries agree. These checks cannot tell whether the right message of a contending pair won, or whether a message was blocked without need. The bench scenarios cover that: the exhaustive single-message sweep, the named contention pair, the conflict-free permutations and the random message sets compared against an independent routing model.

// File: rtl/omega_pkg.sv
package omega_pkg;

  typedef enum logic {SW_PASS = 1'b0, SW_CROSS = 1'b1} sw_mode_e;

  // Left rotation by one bit of an index that is `bits` wide.
  function automatic int shuffle_pos(int pos, int bits);
    int mask;
    mask = (1 << bits) - 1;
    return ((pos << 1) | (pos >> (bits - 1))) & mask;
  endfunction

endpackage

// File: rtl/omega_switch.sv
module omega_switch #(
  parameter int IDX_W   = 3,
  parameter int DATA_W  = 16,
  parameter int SEL_BIT = 2
) (
  input  logic [1:0]             in_v,
  input  logic [1:0][IDX_W-1:0]  in_src,
  input  logic [1:0][IDX_W-1:0]  in_dst,
  input  logic [1:0][DATA_W-1:0] in_dat,
  output logic [1:0]             out_v,
  output logic [1:0][IDX_W-1:0]  out_src,
  output logic [1:0][IDX_W-1:0]  out_dst,
  output logic [1:0][DATA_W-1:0] out_dat,
  output logic                   lose_lo
);
  import omega_pkg::*;

  sw_mode_e mode_up, mode_lo;
  logic     port_up, port_lo;

  always_comb begin
    mode_up = (in_src[0][SEL_BIT] == in_dst[0][SEL_BIT]) ? SW_PASS : SW_CROSS;
    mode_lo = (in_src[1][SEL_BIT] == in_dst[1][SEL_BIT]) ? SW_PASS : SW_CROSS;
    // upper line leaves on port 1 when crossing, lower line on port 1 when passing
    port_up = (mode_up == SW_CROSS);
    port_lo = (mode_lo == SW_PASS);
    lose_lo = in_v[0] & in_v[1] & (port_up == port_lo);

    out_v   = '0;
    out_src = '0;
    out_dst = '0;
    out_dat = '0;
    if (in_v[1] && !lose_lo) begin
      out_v[port_lo]   = 1'b1;
      out_src[port_lo] = in_src[1];
      out_dst[port_lo] = in_dst[1];
      out_dat[port_lo] = in_dat[1];
    end
    if (in_v[0]) begin
      out_v[port_up]   = 1'b1;
      out_src[port_up] = in_src[0];
      out_dst[port_up] = in_dst[0];
      out_dat[port_up] = in_dat[0];
    end
  end

endmodule

// File: rtl/omega_stage.sv
module omega_stage #(
  parameter int NPORT   = 8,
  parameter int IDX_W   = 3,
  parameter int DATA_W  = 16,
  parameter int SEL_BIT = 2
) (
  input  logic [NPORT-1:0]             in_v,
  input  logic [NPORT-1:0][IDX_W-1:0]  in_src,
  input  logic [NPORT-1:0][IDX_W-1:0]  in_dst,
  input  logic [NPORT-1:0][DATA_W-1:0] in_dat,
  output logic [NPORT-1:0]             out_v,
  output logic [NPORT-1:0][IDX_W-1:0]  out_src,
  output logic [NPORT-1:0][IDX_W-1:0]  out_dst,
  output logic [NPORT-1:0][DATA_W-1:0] out_dat,
  output logic [NPORT-1:0]             drop_src
);
  localparam int NSW = NPORT / 2;

  logic [NPORT-1:0]             sh_v;
  logic [NPORT-1:0][IDX_W-1:0]  sh_src;
  logic [NPORT-1:0][IDX_W-1:0]  sh_dst;
  logic [NPORT-1:0][DATA_W-1:0] sh_dat;
  logic [NSW-1:0]               sw_lose;

  for (genvar i = 0; i < NPORT; i++) begin : g_shuffle
    localparam int J = omega_pkg::shuffle_pos(i, IDX_W);
    assign sh_v[J]   = in_v[i];
    assign sh_src[J] = in_src[i];
    assign sh_dst[J] = in_dst[i];
    assign sh_dat[J] = in_dat[i];
  end

  for (genvar s = 0; s < NSW; s++) begin : g_sw
    omega_switch #(
      .IDX_W(IDX_W), .DATA_W(DATA_W), .SEL_BIT(SEL_BIT)
    ) sw_i (
      .in_v   (sh_v[2*s+1:2*s]),
      .in_src (sh_src[2*s+1:2*s]),
      .in_dst (sh_dst[2*s+1:2*s]),
      .in_dat (sh_dat[2*s+1:2*s]),
      .out_v  (out_v[2*s+1:2*s]),
      .out_src(out_src[2*s+1:2*s]),
      .out_dst(out_dst[2*s+1:2*s]),
      .out_dat(out_dat[2*s+1:2*s]),
      .lose_lo(sw_lose[s])
    );
  end

  // Report losers by their source index.
  always_comb begin
    drop_src = '0;
    for (int s = 0; s < NSW; s++) begin
      if (sw_lose[s]) drop_src[sh_src[2*s+1]] = 1'b1;
    end
  end

endmodule

// File: rtl/omega_net.sv
module omega_net #(
  parameter  int NPORT  = 8,
  parameter  int DATA_W = 16,
  localparam int IDX_W  = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NPORT-1:0]             in_valid,
  input  logic [NPORT-1:0][IDX_W-1:0]  in_dest,
  input  logic [NPORT-1:0][DATA_W-1:0] in_data,
  output logic [NPORT-1:0]             out_valid,
  output logic [NPORT-1:0][DATA_W-1:0] out_data,
  output logic [NPORT-1:0][IDX_W-1:0]  out_src,
  output logic [NPORT-1:0]             in_delivered,
  output logic [NPORT-1:0]             in_blocked
);
  localparam int STAGES = IDX_W;

  logic [STAGES:0][NPORT-1:0]             lvl_v;
  logic [STAGES:0][NPORT-1:0][IDX_W-1:0]  lvl_src;
  logic [STAGES:0][NPORT-1:0][IDX_W-1:0]  lvl_dst;
  logic [STAGES:0][NPORT-1:0][DATA_W-1:0] lvl_dat;
  logic [STAGES-1:0][NPORT-1:0]           st_drop;

  logic [NPORT-1:0] blocked_any;
  logic [NPORT-1:0] nxt_valid, nxt_dlv, nxt_blk;
  logic [NPORT-1:0] valid_q, dlv_q, blk_q;
  logic [NPORT-1:0][DATA_W-1:0] data_q;
  logic [NPORT-1:0][IDX_W-1:0]  src_q;

  assign lvl_v[0]   = in_valid;
  assign lvl_dst[0] = in_dest;
  assign lvl_dat[0] = in_data;
  for (genvar i = 0; i < NPORT; i++) begin : g_src
    assign lvl_src[0][i] = IDX_W'(i);
  end

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    omega_stage #(
      .NPORT(NPORT), .IDX_W(IDX_W), .DATA_W(DATA_W), .SEL_BIT(IDX_W-1-g)
    ) stage_i (
      .in_v    (lvl_v[g]),
      .in_src  (lvl_src[g]),
      .in_dst  (lvl_dst[g]),
      .in_dat  (lvl_dat[g]),
      .out_v   (lvl_v[g+1]),
      .out_src (lvl_src[g+1]),
      .out_dst (lvl_dst[g+1]),
      .out_dat (lvl_dat[g+1]),
      .drop_src(st_drop[g])
    );
  end

  // next-state
  always_comb begin
    blocked_any = '0;
    for (int g = 0; g < STAGES; g++) blocked_any |= st_drop[g];
    for (int j = 0; j < NPORT; j++) begin
      // route-integrity qualifier: a line only counts if it carries its own index
      nxt_valid[j] = lvl_v[STAGES][j] & (lvl_dst[STAGES][j] == IDX_W'(j));
    end
    nxt_blk = in_valid & blocked_any;
    nxt_dlv = in_valid & ~blocked_any;
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dlv_q   <= '0;
      blk_q   <= '0;
    end else begin
      valid_q <= nxt_valid;
      dlv_q   <= nxt_dlv;
      blk_q   <= nxt_blk;
    end
  end

  // payload registers, enabled per port
  always_ff @(posedge clk) begin
    for (int j = 0; j < NPORT; j++) begin
      if (nxt_valid[j]) begin
        data_q[j] <= lvl_dat[STAGES][j];
        src_q[j]  <= lvl_src[STAGES][j];
      end
    end
  end

  assign out_valid    = valid_q;
  assign out_data     = data_q;
  assign out_src      = src_q;
  assign in_delivered = dlv_q;
  assign in_blocked   = blk_q;

endmodule

// File: rtl/omega_net_chk.sv
module omega_net_chk #(
  parameter  int NPORT  = 8,
  parameter  int DATA_W = 16,
  localparam int IDX_W  = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NPORT-1:0]             in_valid,
  input logic [NPORT-1:0][IDX_W-1:0]  in_dest,
  input logic [NPORT-1:0][DATA_W-1:0] in_data,
  input logic [NPORT-1:0]             out_valid,
  input logic [NPORT-1:0][DATA_W-1:0] out_data,
  input logic [NPORT-1:0][IDX_W-1:0]  out_src,
  input logic [NPORT-1:0]             in_delivered,
  input logic [NPORT-1:0]             in_blocked
);
  logic [NPORT-1:0]             q_valid;
  logic [NPORT-1:0][IDX_W-1:0]  q_dest;
  logic [NPORT-1:0][DATA_W-1:0] q_data;

  always_ff @(posedge clk) begin
    q_valid <= in_valid;
    q_dest  <= in_dest;
    q_data  <= in_data;
  end

  for (genvar j = 0; j < NPORT; j++) begin : g_chk
    // R1: output j holds a message sampled last cycle that was addressed to j
    a_r1_dest_match: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[j] |-> (q_valid[out_src[j]] && q_dest[out_src[j]] == IDX_W'(j)));
    // R1: payload belongs to the reported source, which was told it was delivered
    a_r1_payload: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[j] |-> (out_data[j] == q_data[out_src[j]] && in_delivered[out_src[j]]));
    // R4: one flag per valid input
    a_r4_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid[j] |=> (in_delivered[j] ^ in_blocked[j]));
    // R6: idle input raises nothing
    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid[j] |=> (!in_delivered[j] && !in_blocked[j]));
  end

  // R8
  a_r8_count_match: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(out_valid) == $countones(in_delivered));

endmodule

bind omega_net omega_net_chk #(.NPORT(NPORT), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/omega_net_tb_top.sv
module omega_net_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int P  = 8;
  localparam int W  = 3;
  localparam int DW = 16;

  logic                   clk;
  logic                   rst_n;
  logic [P-1:0]           in_valid;
  logic [P-1:0][W-1:0]    in_dest;
  logic [P-1:0][DW-1:0]   in_data;
  logic [P-1:0]           out_valid;
  logic [P-1:0][DW-1:0]   out_data;
  logic [P-1:0][W-1:0]    out_src;
  logic [P-1:0]           in_delivered;
  logic [P-1:0]           in_blocked;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  omega_net #(.NPORT(P), .DATA_W(DW)) dut_i (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference: position-based walk, output port picked by destination bit.
  task automatic model(input logic [P-1:0] v, input logic [P-1:0][W-1:0] d,
                       output logic [P-1:0] dlv, output logic [P-1:0] ov,
                       output logic [P-1:0][W-1:0] osrc);
    int pos[P]; int q[P]; int np[P]; bit alive[P]; bit kill[P];
    for (int i = 0; i < P; i++) begin alive[i] = v[i]; pos[i] = i; end
    for (int k = 0; k < W; k++) begin
      for (int i = 0; i < P; i++) begin
        q[i]  = ((pos[i] << 1) | (pos[i] >> (W-1))) & (P-1);
        np[i] = (q[i] & ~1) | int'(d[i][W-1-k]);
        kill[i] = 0;
      end
      for (int i = 0; i < P; i++)
        for (int j = 0; j < P; j++)
          if (i != j && alive[i] && alive[j] && np[i] == np[j] && q[i][0]) kill[i] = 1;
      for (int i = 0; i < P; i++) begin
        if (kill[i]) alive[i] = 0;
        pos[i] = np[i];
      end
    end
    dlv = '0; ov = '0; osrc = '0;
    for (int i = 0; i < P; i++)
      if (alive[i]) begin dlv[i] = 1; ov[pos[i]] = 1; osrc[pos[i]] = W'(i); end
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // drive one vector, compare everything against the model one clock later
  task automatic run_vec(input logic [P-1:0] v, input logic [P-1:0][W-1:0] d,
                         input logic [P-1:0][DW-1:0] dat, input string tag);
    logic [P-1:0] edlv, eov; logic [P-1:0][W-1:0] esrc; bit ok;
    @(negedge clk);
    in_valid = v; in_dest = d; in_data = dat;
    @(negedge clk);
    model(v, d, edlv, eov, esrc);
    ok = (in_delivered == edlv) && (in_blocked == (v & ~edlv)) && (out_valid == eov);
    for (int j = 0; j < P; j++)
      if (eov[j] && (out_src[j] != esrc[j] || out_data[j] != dat[esrc[j]])) ok = 0;
    check(ok, tag, "vector dlv/blk/ov", {40'd0, in_delivered, in_blocked, out_valid},
          {40'd0, edlv, v & ~edlv, eov});
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = '0; in_dest = '0; in_data = '0;
  endtask

  initial begin
    logic [P-1:0][W-1:0]  d;
    logic [P-1:0][DW-1:0] dat;
    logic [P-1:0]         v;
    void'($urandom(32'd2024));
    rst_n = 1'b0; in_valid = '0; in_dest = '0; in_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R7: reset state
    check(out_valid == '0 && in_delivered == '0 && in_blocked == '0, "R7", "reset state",
          {40'd0, out_valid, in_delivered, in_blocked}, 64'd0);
    rst_n = 1'b1;

    // R6: idle network stays quiet
    run_vec('0, '0, '0, "R6");
    check(out_valid == '0 && in_blocked == '0, "R6", "idle outputs",
          {48'd0, out_valid, in_blocked}, 64'd0);

    // R2: every lone source/destination pair
    for (int s = 0; s < P; s++)
      for (int t = 0; t < P; t++) begin
        d = '0; dat = '0; v = '0;
        v[s] = 1'b1; d[s] = W'(t); dat[s] = DW'($urandom);
        run_vec(v, d, dat, "R2");
        check(in_delivered[s] && out_valid[t] && out_src[t] == W'(s), "R2", "lone delivery",
              {56'd0, in_delivered}, 64'(1) << s);
      end

    // R1 and R5: 1 -> 4, outputs unchanged before the clock edge
    idle();
    @(negedge clk);
    d = '0; dat = '0; v = '0;
    v[1] = 1'b1; d[1] = 3'd4; dat[1] = 16'hBEEF;
    in_valid = v; in_dest = d; in_data = dat;
    #1;
    check(out_valid == '0 && in_delivered == '0, "R5", "no change before edge",
          {56'd0, out_valid}, 64'd0);
    @(negedge clk);
    check(out_valid == 8'h10, "R5", "arrival one clock later", {56'd0, out_valid}, 64'h10);
    check(out_src[4] == 3'd1 && out_data[4] == 16'hBEEF, "R1", "1->4 src/payload",
          {45'd0, out_src[4], out_data[4]}, {45'd0, 3'd1, 16'hBEEF});

    // R3: 2 -> 7 against 6 -> 4
    d = '0; v = '0; dat = '0;
    v[2] = 1; d[2] = 3'd7; dat[2] = 16'h0202;
    v[6] = 1; d[6] = 3'd4; dat[6] = 16'h0606;
    idle();
    run_vec(v, d, dat, "R3");
    check(in_delivered == 8'h04 && in_blocked == 8'h40, "R3", "lower line wins",
          {48'd0, in_delivered, in_blocked}, {48'd0, 8'h04, 8'h40});
    check(out_valid == 8'h80 && out_data[7] == 16'h0202, "R3", "winner at 7",
          {48'd0, out_valid, 8'd0}, {48'd0, 8'h80, 8'd0});

    // R9: identity and cyclic shifts
    for (int sh = 0; sh < P; sh++) begin
      for (int i = 0; i < P; i++) begin d[i] = W'((i + sh) % P); dat[i] = DW'($urandom); end
      run_vec('1, d, dat, "R9");
      check(in_delivered == '1 && out_valid == '1, "R9", "shift all delivered",
            {48'd0, in_delivered, out_valid}, {48'd0, 8'hFF, 8'hFF});
    end

    // R4 and R8: random message sets
    for (int n = 0; n < 400; n++) begin
      v = P'($urandom);
      for (int i = 0; i < P; i++) begin d[i] = W'($urandom); dat[i] = DW'($urandom); end
      run_vec(v, d, dat, "R4");
      check($countones(out_valid) == $countones(in_delivered), "R8", "count match",
            64'($countones(out_valid)), 64'($countones(in_delivered)));
    end

    // R7: reset in mid-run clears outputs
    run_vec('1, d, dat, "R4");
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(out_valid == '0 && in_delivered == '0 && in_blocked == '0, "R7", "mid-run reset",
          {40'd0, out_valid, in_delivered, in_blocked}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    idle();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule